// File: doc/BRIEF.md
# Semaphore Wait and Update Gate

This block sits between an instruction source and an engine's execute stage. Each instruction arrives with an 8-byte synchronization block. The gate holds the instruction until a named counting semaphore reaches a threshold. When the engine later reports that the instruction has completed, the gate increments a second named semaphore. The gate owns a bank of 32 semaphores, each 32 bits wide.

Other engines and DMA completions bump semaphores through a separate increment port. Any semaphore can be observed through a combinational read port. The gate does not decode instructions and does not execute them. It sees only the synchronization block, and it passes the captured update mode and index out with the instruction so that the engine can return them with its completion pulse.

Top module: `sem_gate`

## Requirements
- R1: A synchronous active-high `rst` clears every semaphore to zero and empties the holding register. In the cycle after reset, `inReady` is 1, `outValid` is 0 and `errFlag` is 0.
- R2: `inSync` is laid out little-endian. Bits 7:0 hold the wait mode, bits 15:8 the wait index, bits 23:16 the update mode, bits 31:24 the update index, and bits 63:32 the 32-bit value. Only the low 5 bits of each index byte select a semaphore.
- R3: Wait mode 0x04 keeps `outValid` low until the indexed semaphore is greater than or equal to the value field.
- R4: Under wait mode 0x04, a value field of 0 is treated as a threshold of 1. The instruction therefore waits until the semaphore is nonzero.
- R5: Wait mode 0x00 means no wait. A block of all zeros raises `outValid` in the cycle after the instruction is accepted.
- R6: A `doneValid` pulse with update mode 0x13 increments semaphore `doneUpdIdx` by one, and the new value is visible from the next cycle. Update mode 0x00 changes nothing.
- R7: An accepted block whose wait mode is neither 0x00 nor 0x04, or whose update mode is neither 0x00 nor 0x13, raises `errFlag` for one cycle, in the cycle after acceptance. An unknown wait mode does not stall the instruction. An unknown update mode returned on completion changes no semaphore.
- R8: `extIncValid` increments semaphore `extIncIdx` by one. If an external increment and a completion increment hit the same semaphore in the same cycle, the semaphore rises by 2. If they hit different semaphores, each rises by 1.
- R9: Only one instruction is held at a time. `inReady` is low from the cycle after acceptance until the cycle after issue, and issue happens when `outValid` and `outReady` are both high. Input offered while `inReady` is low is ignored.
- R10: `rdData` always equals the current value of semaphore `rdIdx`.
- R11: While `outValid` is high, `outUpdMode` and `outUpdIdx` carry the update mode and index of the held instruction. They stay stable until issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Gate can accept an instruction |
| inSync | input | 64 | Synchronization block of the offered instruction |
| outValid | output | 1 | Held instruction may issue |
| outReady | input | 1 | Execute stage takes the instruction |
| outUpdMode | output | 8 | Update mode captured at acceptance |
| outUpdIdx | output | 5 | Update index captured at acceptance |
| doneValid | input | 1 | Completion pulse from the engine |
| doneUpdMode | input | 8 | Update mode returned with the completion |
| doneUpdIdx | input | 5 | Update index returned with the completion |
| extIncValid | input | 1 | External increment request |
| extIncIdx | input | 5 | Semaphore targeted by the external increment |
| rdIdx | input | 5 | Semaphore selected for observation |
| rdData | output | 32 | Value of the selected semaphore |
| errFlag | output | 1 | Unknown mode byte seen at acceptance |

## Verification
The hardest situation to create is a held instruction whose threshold is crossed in exactly the cycle that other traffic lands on the same semaphore. The reference and the design must then agree on the cycle in which `outValid` rises. The stimulus forces this situation directly: an external increment and a completion increment are aimed at one index in one cycle, and a waiting instruction is released by single external bumps spaced apart. A long random phase then mixes waits, thresholds of 0 to 3, back-pressure and mode bytes that are unknown. The read index is swept every cycle throughout.

// File: rtl/sem_gate_pkg.sv
package sem_gate_pkg;
  localparam int SEM_COUNT = 32;
  localparam int SEM_IDX_W = $clog2(SEM_COUNT);
  localparam int SEM_WIDTH = 32;

  localparam logic [7:0] WAIT_NONE = 8'h00;
  localparam logic [7:0] WAIT_GE   = 8'h04;
  localparam logic [7:0] UPD_NONE  = 8'h00;
  localparam logic [7:0] UPD_INC   = 8'h13;

  // little-endian block: lowest byte is the wait mode
  typedef struct packed {
    logic [31:0] value;
    logic [7:0]  updIdx;
    logic [7:0]  updMode;
    logic [7:0]  waitIdx;
    logic [7:0]  waitMode;
  } syncBlk_t;

  // strobes from control to the semaphore bank
  typedef struct packed {
    logic                 extEn;
    logic [SEM_IDX_W-1:0] extIdx;
    logic                 cplEn;
    logic [SEM_IDX_W-1:0] cplIdx;
  } incStrobe_t;
endpackage

// File: rtl/sem_gate_bank.sv
module sem_gate_bank
  import sem_gate_pkg::*;
#(
  parameter int NUM_SEM = SEM_COUNT,
  parameter int SEM_W   = SEM_WIDTH,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  incStrobe_t       strobes,
  input  logic [IDX_W-1:0] waitIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [SEM_W-1:0] waitSemVal,
  output logic [SEM_W-1:0] rdData
);
  logic [SEM_W-1:0] semReg [NUM_SEM];

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    logic       extHit;
    logic       cplHit;
    logic [1:0] bump;

    assign extHit = strobes.extEn && (strobes.extIdx == IDX_W'(i));
    assign cplHit = strobes.cplEn && (strobes.cplIdx == IDX_W'(i));
    // both sources on one semaphore add together
    assign bump   = {1'b0, extHit} + {1'b0, cplHit};

    always_ff @(posedge clk) begin
      if (rst) semReg[i] <= '0;
      else     semReg[i] <= semReg[i] + SEM_W'(bump);
    end
  end

  assign waitSemVal = semReg[waitIdx];
  assign rdData     = semReg[rdIdx];
endmodule

// File: rtl/sem_gate_ctrl.sv
module sem_gate_ctrl
  import sem_gate_pkg::*;
#(
  parameter int SEM_W = SEM_WIDTH,
  parameter int IDX_W = SEM_IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic [63:0]      inSync,
  output logic             outValid,
  input  logic             outReady,
  output logic [7:0]       outUpdMode,
  output logic [IDX_W-1:0] outUpdIdx,
  input  logic             doneValid,
  input  logic [7:0]       doneUpdMode,
  input  logic [IDX_W-1:0] doneUpdIdx,
  input  logic             extIncValid,
  input  logic [IDX_W-1:0] extIncIdx,
  input  logic [SEM_W-1:0] waitSemVal,
  output logic [IDX_W-1:0] waitIdx,
  output incStrobe_t       strobes,
  output logic             errFlag
);
  syncBlk_t blk;
  assign blk = syncBlk_t'(inSync);

  logic             held;
  logic [7:0]       hWaitMode;
  logic [IDX_W-1:0] hWaitIdx;
  logic [SEM_W-1:0] hWaitThr;
  logic [7:0]       hUpdMode;
  logic [IDX_W-1:0] hUpdIdx;

  logic accept, issue, waitOk, waitKnown, updKnown;
  logic [SEM_W-1:0] newThr;
  logic unusedIdxHi;

  assign unusedIdxHi = ^{blk.waitIdx[7:IDX_W], blk.updIdx[7:IDX_W]};

  assign inReady = !held;
  assign accept  = inValid && inReady;
  assign issue   = outValid && outReady;

  assign waitKnown = (blk.waitMode == WAIT_NONE) || (blk.waitMode == WAIT_GE);
  assign updKnown  = (blk.updMode == UPD_NONE) || (blk.updMode == UPD_INC);

  // a zero value waits for a nonzero semaphore
  assign newThr = (blk.value == '0) ? SEM_W'(1) : SEM_W'(blk.value);

  // unknown wait modes fall through as no wait
  assign waitOk   = (hWaitMode != WAIT_GE) || (waitSemVal >= hWaitThr);
  assign outValid = held && waitOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= 1'b0;
      hWaitMode <= WAIT_NONE;
      hWaitIdx  <= '0;
      hWaitThr  <= '0;
      hUpdMode  <= UPD_NONE;
      hUpdIdx   <= '0;
      errFlag   <= 1'b0;
    end else begin
      errFlag <= accept && !(waitKnown && updKnown);
      if (issue) begin
        held <= 1'b0;
      end else if (accept) begin
        held      <= 1'b1;
        hWaitMode <= blk.waitMode;
        hWaitIdx  <= blk.waitIdx[IDX_W-1:0];
        hWaitThr  <= newThr;
        hUpdMode  <= blk.updMode;
        hUpdIdx   <= blk.updIdx[IDX_W-1:0];
      end
    end
  end

  assign waitIdx    = hWaitIdx;
  assign outUpdMode = hUpdMode;
  assign outUpdIdx  = hUpdIdx;

  always_comb begin
    strobes.extEn  = extIncValid;
    strobes.extIdx = extIncIdx;
    strobes.cplEn  = doneValid && (doneUpdMode == UPD_INC);
    strobes.cplIdx = doneUpdIdx;
  end
endmodule

// File: rtl/sem_gate.sv
module sem_gate
  import sem_gate_pkg::*;
#(
  parameter int NUM_SEM = SEM_COUNT,
  parameter int SEM_W   = SEM_WIDTH,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic [63:0]      inSync,
  output logic             outValid,
  input  logic             outReady,
  output logic [7:0]       outUpdMode,
  output logic [IDX_W-1:0] outUpdIdx,
  input  logic             doneValid,
  input  logic [7:0]       doneUpdMode,
  input  logic [IDX_W-1:0] doneUpdIdx,
  input  logic             extIncValid,
  input  logic [IDX_W-1:0] extIncIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [SEM_W-1:0] rdData,
  output logic             errFlag
);
  incStrobe_t       strobes;
  logic [IDX_W-1:0] waitIdx;
  logic [SEM_W-1:0] waitSemVal;

  sem_gate_ctrl #(.SEM_W(SEM_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .inValid(inValid), .inReady(inReady), .inSync(inSync),
    .outValid(outValid), .outReady(outReady),
    .outUpdMode(outUpdMode), .outUpdIdx(outUpdIdx),
    .doneValid(doneValid), .doneUpdMode(doneUpdMode), .doneUpdIdx(doneUpdIdx),
    .extIncValid(extIncValid), .extIncIdx(extIncIdx),
    .waitSemVal(waitSemVal), .waitIdx(waitIdx),
    .strobes(strobes), .errFlag(errFlag)
  );

  sem_gate_bank #(.NUM_SEM(NUM_SEM), .SEM_W(SEM_W)) u_bank (
    .clk(clk), .rst(rst),
    .strobes(strobes), .waitIdx(waitIdx), .rdIdx(rdIdx),
    .waitSemVal(waitSemVal), .rdData(rdData)
  );
endmodule

// File: rtl/sem_gate_chk.sv
module sem_gate_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        inReady,
  input logic [63:0] inSync,
  input logic        outValid,
  input logic        outReady,
  input logic [7:0]  outUpdMode,
  input logic [4:0]  outUpdIdx,
  input logic        doneValid,
  input logic [7:0]  doneUpdMode,
  input logic [4:0]  doneUpdIdx,
  input logic        extIncValid,
  input logic [4:0]  extIncIdx,
  input logic [4:0]  rdIdx,
  input logic [31:0] rdData,
  input logic        errFlag
);
  logic cplInc, badMode;
  assign cplInc  = doneValid && (doneUpdMode == 8'h13);
  assign badMode = !((inSync[7:0] == 8'h00) || (inSync[7:0] == 8'h04)) ||
                   !((inSync[23:16] == 8'h00) || (inSync[23:16] == 8'h13));

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (inReady && !outValid && !errFlag));

  a_r9_single_hold: assert property (@(posedge clk) disable iff (rst)
    (!inReady && !(outValid && outReady)) |=> !inReady);

  a_r9_accept_blocks: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady);

  a_r11_stable_until_issue: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outUpdMode) && $stable(outUpdIdx)));

  a_r7_err_on_bad_mode: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && badMode) |=> errFlag);

  a_r7_err_only_after_accept: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> $past(inValid && inReady));

  a_r8_ext_plus_one: assert property (@(posedge clk) disable iff (rst)
    (extIncValid && !(cplInc && doneUpdIdx == extIncIdx) && rdIdx == extIncIdx)
      |=> ((rdIdx != $past(rdIdx)) || (rdData == $past(rdData) + 32'd1)));

  a_r6_cpl_plus_one: assert property (@(posedge clk) disable iff (rst)
    (cplInc && !(extIncValid && extIncIdx == doneUpdIdx) && rdIdx == doneUpdIdx)
      |=> ((rdIdx != $past(rdIdx)) || (rdData == $past(rdData) + 32'd1)));

  a_r8_both_plus_two: assert property (@(posedge clk) disable iff (rst)
    (cplInc && extIncValid && extIncIdx == doneUpdIdx && rdIdx == doneUpdIdx)
      |=> ((rdIdx != $past(rdIdx)) || (rdData == $past(rdData) + 32'd2)));
endmodule

bind sem_gate sem_gate_chk u_chk (.*);

// File: tb/tb_sem_gate.sv
module tb_sem_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inSync = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [7:0]  outUpdMode;
  logic [4:0]  outUpdIdx;
  logic        doneValid = 1'b0;
  logic [7:0]  doneUpdMode = '0;
  logic [4:0]  doneUpdIdx = '0;
  logic        extIncValid = 1'b0;
  logic [4:0]  extIncIdx = '0;
  logic [4:0]  rdIdx = '0;
  logic [31:0] rdData;
  logic        errFlag;

  always #10 clk = ~clk;

  sem_gate dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inSync(inSync),
    .outValid(outValid), .outReady(outReady), .outUpdMode(outUpdMode),
    .outUpdIdx(outUpdIdx), .doneValid(doneValid), .doneUpdMode(doneUpdMode),
    .doneUpdIdx(doneUpdIdx), .extIncValid(extIncValid), .extIncIdx(extIncIdx),
    .rdIdx(rdIdx), .rdData(rdData), .errFlag(errFlag)
  );

  // behavioural reference
  int unsigned mSem [32];
  bit          mHeld;
  bit          mErr;
  logic [7:0]  mWaitMode, mUpdMode;
  int          mWaitIdx, mUpdIdx;
  int unsigned mVal;
  bit          armed = 0;
  bit          autoDone = 1;
  int          nChk = 0;
  int          nBad = 0;
  string       curReq = "R1";
  logic [12:0] cplQ [$];

  function automatic bit mOutValid();
    int unsigned thr;
    if (!mHeld) return 0;
    if (mWaitMode != 8'h04) return 1;
    thr = (mVal == 0) ? 1 : mVal;
    return mSem[mWaitIdx] >= thr;
  endfunction

  always @(posedge clk) begin
    bit iss;
    armed <= 1;
    if (rst) begin
      foreach (mSem[i]) mSem[i] = 0;
      mHeld = 0;
      mErr  = 0;
    end else begin
      iss  = mOutValid() && outReady;
      mErr = 0;
      if (iss) mHeld = 0;
      else if (!mHeld && inValid) begin
        mHeld     = 1;
        mWaitMode = inSync[7:0];
        mWaitIdx  = int'(inSync[12:8]);
        mUpdMode  = inSync[23:16];
        mUpdIdx   = int'(inSync[28:24]);
        mVal      = inSync[63:32];
        mErr      = !(mWaitMode == 8'h00 || mWaitMode == 8'h04) ||
                    !(mUpdMode == 8'h00 || mUpdMode == 8'h13);
      end
      if (extIncValid) mSem[extIncIdx] = mSem[extIncIdx] + 1;
      if (doneValid && doneUpdMode == 8'h13) mSem[doneUpdIdx] = mSem[doneUpdIdx] + 1;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (armed) begin
      chk("inReady (R9)", 32'(inReady), 32'(!mHeld));
      chk("outValid (R3 R4 R5)", 32'(outValid), 32'(mOutValid()));
      chk("errFlag (R7)", 32'(errFlag), 32'(mErr));
      chk("rdData (R10)", rdData, mSem[rdIdx]);
      if (mOutValid()) begin
        chk("outUpdMode (R11)", 32'(outUpdMode), 32'(mUpdMode));
        chk("outUpdIdx (R11)", 32'(outUpdIdx), 32'(mUpdIdx));
      end
      if (!rst && autoDone && outValid && outReady) cplQ.push_back({outUpdMode, outUpdIdx});
    end
  end

  // engine stand-in: completes one cycle after issue
  always @(posedge clk) begin
    #1;
    if (autoDone) begin
      if (cplQ.size() > 0) begin
        {doneUpdMode, doneUpdIdx} = cplQ.pop_front();
        doneValid = 1;
      end else doneValid = 0;
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [63:0] mk(logic [7:0] wm, logic [7:0] wi, logic [7:0] um,
                                     logic [7:0] ui, logic [31:0] v);
    return {v, ui, um, wi, wm};
  endfunction

  task automatic send(logic [63:0] b);
    while (mHeld) step(1);
    inValid = 1; inSync = b;
    step(1);
    inValid = 0;
  endtask

  task automatic bumpExt(logic [4:0] idx);
    extIncValid = 1; extIncIdx = idx;
    step(1);
    extIncValid = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog %s actual=hung expected=finished", curReq);
    summary();
    $finish;
  end

  initial begin
    // R1: reset state, all semaphores read zero
    curReq = "R1";
    step(3);
    rst = 0;
    for (int i = 0; i < 32; i++) begin rdIdx = 5'(i); step(1); end

    // R5: all-zero block issues at once
    curReq = "R5";
    send(64'h0);
    step(3);

    // R2 R3: wait idx 10 >= 3, then increment idx 22 on completion (R6)
    curReq = "R3";
    rdIdx = 5'd10;
    send(mk(8'h04, 8'd10, 8'h13, 8'd22, 32'd3));
    step(3);
    for (int k = 0; k < 3; k++) begin bumpExt(5'd10); step(2); end
    curReq = "R6";
    rdIdx = 5'd22;
    step(4);
    curReq = "R2";
    send(mk(8'h04, 8'hEA, 8'h13, 8'hF6, 32'd1)); // upper index bits ignored
    step(4);

    // R4: zero value waits for nonzero
    curReq = "R4";
    rdIdx = 5'd5;
    send(mk(8'h04, 8'd5, 8'h00, 8'd0, 32'd0));
    step(4);
    bumpExt(5'd5);
    step(3);

    // R7: unknown modes flag and act as no-ops
    curReq = "R7";
    rdIdx = 5'd3;
    send(mk(8'h07, 8'd0, 8'h22, 8'd3, 32'd9));
    step(4);
    send(mk(8'h00, 8'd0, 8'h55, 8'd3, 32'd0));
    step(4);

    // R9 R11: back-pressure, extra offers ignored
    curReq = "R9";
    outReady = 0;
    send(mk(8'h00, 8'd0, 8'h13, 8'd9, 32'd0));
    inValid = 1; inSync = mk(8'h00, 8'd0, 8'h13, 8'd12, 32'd0);
    step(2);
    inValid = 0;
    curReq = "R11";
    step(3);
    outReady = 1;
    rdIdx = 5'd12;
    step(4);

    // R8: simultaneous increments
    curReq = "R8";
    step(2);
    autoDone = 0;
    doneValid = 0;
    rdIdx = 5'd7;
    extIncValid = 1; extIncIdx = 5'd7;
    doneValid = 1; doneUpdMode = 8'h13; doneUpdIdx = 5'd7;
    step(1);
    extIncIdx = 5'd8; doneUpdIdx = 5'd9; rdIdx = 5'd9;
    step(1);
    extIncValid = 0;
    curReq = "R6";
    doneUpdMode = 8'h00;
    step(1);
    doneValid = 0;
    step(2);
    autoDone = 1;

    // R10: random mix
    curReq = "R10";
    for (int c = 0; c < 1500; c++) begin
      logic [7:0] wm, um;
      case ($urandom % 5)
        0: wm = 8'h00; 1, 2: wm = 8'h04; 3: wm = 8'h04; default: wm = 8'h1C;
      endcase
      case ($urandom % 4)
        0: um = 8'h00; 1, 2: um = 8'h13; default: um = 8'h31;
      endcase
      rdIdx       = 5'($urandom);
      extIncValid = ($urandom % 2) == 0;
      extIncIdx   = 5'($urandom % 8);
      outReady    = ($urandom % 4) != 0;
      inValid     = ($urandom % 3) == 0;
      inSync      = mk(wm, 8'($urandom % 8), um, 8'($urandom % 8), 32'($urandom % 4));
      step(1);
    end
    inValid = 0; extIncValid = 0; outReady = 1;
    step(5);

    summary();
    $finish;
  end
endmodule